// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces memory addresses for indirect data access in a DSP datapath. It keeps three banks of four 14-bit registers: an index bank, a modify bank and a length bank. When an access is requested, the selected index register is driven out as the address in the same cycle. At the next clock edge that index register is post-modified by adding a selected signed modify register. When the length register paired with that index is nonzero, the new value wraps inside a circular buffer of that length. When the length is zero, the index simply steps linearly.

The buffer base is the current index with its low ceil(log2(L)) bits cleared. Buffers must therefore start on a power-of-two boundary that is at least L, and the magnitude of the step must be below L. A reverse-order output mode mirrors the bits of the address for FFT data ordering. It leaves the stored index and its update untouched. All twelve registers are written and read back over a 16-bit data bus. The access request has no ready: the generator accepts a request in every cycle and never applies back-pressure.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every index, modify and length register reads back as 0x0000.
- R2: While access_valid is high and bitrev_en is low, addr_out equals the index register chosen by i_sel in that same cycle, before modification.
- R3: On a clock edge with access_valid high, index register i_sel becomes its old value plus modify register m_sel. The two selections are independent, and the other index registers keep their values.
- R4: Modify values are 14-bit two's complement, so a negative modify register lowers the index.
- R5: With the paired length register at zero, the update is linear and wraps modulo 2^14 (0x0001 minus 2 gives 0x3FFF).
- R6: With length L nonzero and base = index with its low ceil(log2(L)) bits cleared, a sum at or above base+L has L subtracted (L=5, index 0x23, step +2 gives 0x20).
- R7: With L nonzero, a sum below base has L added (L=5, index 0x20, step -2 gives 0x23).
- R8: With bitrev_en high, addr_out is the selected index with bit k moved to bit 13-k (0x0001 gives 0x2000). The stored index still updates in normal bit order.
- R9: reg_file_sel encodes 0 = index, 1 = modify, 2 = length. Writes take wdata[13:0] and ignore wdata[15:14]. Reads of index and length registers return zeros in rdata[15:14], and reads of a modify register copy bit 13 into bits 15:14.
- R10: A register write to the index register being post-modified in the same cycle takes priority, and the written value is kept.
- R11: rdata is 0x0000 while reg_rd is low. reg_file_sel = 3 selects no register: writes to it change nothing and reads of it return 0x0000.
- R12: In a cycle with access_valid low and no register write, no index register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| access_valid | input | 1 | Indirect access request; the post-modify happens at the edge |
| i_sel | input | 2 | Index register used for the address and the update |
| m_sel | input | 2 | Modify register added to the index |
| bitrev_en | input | 1 | Reverse the bit order of addr_out |
| addr_out | output | 14 | Access address, combinational from the current index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_file_sel | input | 2 | Register bank: 0 index, 1 modify, 2 length, 3 none |
| reg_idx | input | 2 | Register number within the bank |
| wdata | input | 16 | Write data; only bits 13:0 are stored |
| rdata | output | 16 | Read data, combinational, zero when reg_rd is low |

## Verification
The post-modify is driven with a positive step and with a negative step on a linear buffer. This separates sign-extension errors from plain adder errors. The linear underflow through zero shows whether a zero length really disables wrapping. Circular steps that land exactly on base+L and just below base check the upper and lower boundary comparisons separately. Both tests use a non-power-of-two length, so a base taken from the wrong mask or an add/subtract swapped between the two directions gives a wrong index. Reverse-order accesses followed by a readback show that only the output is mirrored and not the stored index.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    FILE_IDX  = 2'd0,
    FILE_MOD  = 2'd1,
    FILE_LEN  = 2'd2,
    FILE_NONE = 2'd3
  } file_e;
endpackage

// File: rtl/dag_bank.sv
module dag_bank #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SW-1:0]      wr_idx,
  input  logic [AW-1:0]      wr_data,
  input  logic               upd_en,
  input  logic [SW-1:0]      upd_idx,
  input  logic [AW-1:0]      upd_data,
  output logic [NREG*AW-1:0] q_flat
);
  logic [AW-1:0] regs [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[gi] <= '0;
      else if (wr_en && wr_idx == SW'(gi))
        regs[gi] <= wr_data;          // bus write wins (R10)
      else if (upd_en && upd_idx == SW'(gi))
        regs[gi] <= upd_data;
    end
    assign q_flat[gi*AW +: AW] = regs[gi];
  end
endmodule

// File: rtl/dag_modulo.sv
module dag_modulo #(
  parameter int AW = 14,
  localparam int EW = AW + 2
) (
  input  logic [AW-1:0] idx_val,
  input  logic [AW-1:0] mod_val,
  input  logic [AW-1:0] len_val,
  output logic [AW-1:0] next_val
);
  function automatic logic [AW-1:0] smear(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    r = v;
    for (int k = 1; k < AW; k++) r = r | (r >> k);
    return r;
  endfunction

  logic [AW-1:0]        mask, base;
  logic signed [EW-1:0] s_idx, s_mod, s_sum, s_len, s_base, s_lim, s_res;

  always_comb begin
    mask   = smear(len_val - AW'(1));
    base   = idx_val & ~mask;
    s_idx  = signed'({2'b00, idx_val});
    s_mod  = signed'({{2{mod_val[AW-1]}}, mod_val});
    s_len  = signed'({2'b00, len_val});
    s_base = signed'({2'b00, base});
    s_sum  = s_idx + s_mod;
    s_lim  = s_base + s_len;
    s_res  = s_sum;
    if (len_val != '0) begin
      if (s_sum >= s_lim)       s_res = s_sum - s_len;   // R6
      else if (s_sum < s_base)  s_res = s_sum + s_len;   // R7
    end
    next_val = s_res[AW-1:0];                            // R5 linear wrap
  end
endmodule

// File: rtl/dag_bitrev.sv
module dag_bitrev #(
  parameter int AW = 14
) (
  input  logic          en,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] dout
);
  logic [AW-1:0] rev;
  for (genvar gi = 0; gi < AW; gi++) begin : g_rev
    assign rev[gi] = din[AW-1-gi];
  end
  assign dout = en ? rev : din;   // R8
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int ADDR_W = 14,
  parameter int BUS_W  = 16,
  parameter int NREG   = 4,
  localparam int SEL_W = $clog2(NREG),
  localparam int PAD_W = BUS_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_valid,
  input  logic [SEL_W-1:0]  i_sel,
  input  logic [SEL_W-1:0]  m_sel,
  input  logic              bitrev_en,
  output logic [ADDR_W-1:0] addr_out,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_file_sel,
  input  logic [SEL_W-1:0]  reg_idx,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata
);
  import dag_pkg::*;

  file_e                   fsel;
  logic [NREG*ADDR_W-1:0]  idx_flat, mod_flat, len_flat;
  logic [ADDR_W-1:0]       idx_cur, mod_cur, len_cur, idx_next;
  logic [ADDR_W-1:0]       wr_val, rd_idx, rd_mod, rd_len;
  logic                    we_idx, we_mod, we_len;

  assign fsel   = file_e'(reg_file_sel);
  assign wr_val = wdata[ADDR_W-1:0];               // upper bits dropped (R9)
  assign we_idx = reg_wr && fsel == FILE_IDX;
  assign we_mod = reg_wr && fsel == FILE_MOD;
  assign we_len = reg_wr && fsel == FILE_LEN;      // FILE_NONE writes nothing (R11)

  dag_bank #(.AW(ADDR_W), .NREG(NREG)) u_idx_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(we_idx), .wr_idx(reg_idx), .wr_data(wr_val),
    .upd_en(access_valid), .upd_idx(i_sel), .upd_data(idx_next),
    .q_flat(idx_flat)
  );

  dag_bank #(.AW(ADDR_W), .NREG(NREG)) u_mod_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(we_mod), .wr_idx(reg_idx), .wr_data(wr_val),
    .upd_en(1'b0), .upd_idx('0), .upd_data('0),
    .q_flat(mod_flat)
  );

  dag_bank #(.AW(ADDR_W), .NREG(NREG)) u_len_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(we_len), .wr_idx(reg_idx), .wr_data(wr_val),
    .upd_en(1'b0), .upd_idx('0), .upd_data('0),
    .q_flat(len_flat)
  );

  assign idx_cur = idx_flat[i_sel*ADDR_W +: ADDR_W];
  assign mod_cur = mod_flat[m_sel*ADDR_W +: ADDR_W];
  assign len_cur = len_flat[i_sel*ADDR_W +: ADDR_W];

  dag_modulo #(.AW(ADDR_W)) u_modulo (
    .idx_val(idx_cur), .mod_val(mod_cur), .len_val(len_cur),
    .next_val(idx_next)
  );

  dag_bitrev #(.AW(ADDR_W)) u_bitrev (
    .en(bitrev_en), .din(idx_cur), .dout(addr_out)
  );

  assign rd_idx = idx_flat[reg_idx*ADDR_W +: ADDR_W];
  assign rd_mod = mod_flat[reg_idx*ADDR_W +: ADDR_W];
  assign rd_len = len_flat[reg_idx*ADDR_W +: ADDR_W];

  always_comb begin
    rdata = '0;
    if (reg_rd) begin
      unique case (fsel)
        FILE_IDX: rdata = {{PAD_W{1'b0}}, rd_idx};
        FILE_MOD: rdata = {{PAD_W{rd_mod[ADDR_W-1]}}, rd_mod};
        FILE_LEN: rdata = {{PAD_W{1'b0}}, rd_len};
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dag_addr_checker.sv
module dag_addr_checker #(
  parameter int ADDR_W = 14,
  parameter int BUS_W  = 16,
  parameter int NREG   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   access_valid,
  input logic                   reg_wr,
  input logic                   reg_rd,
  input logic [1:0]             reg_file_sel,
  input logic [BUS_W-1:0]       rdata,
  input logic [NREG*ADDR_W-1:0] idx_flat
);
  assert_unsigned_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_file_sel == 2'd0 || reg_file_sel == 2'd2)) |-> rdata[BUS_W-1:ADDR_W] == '0);

  assert_signed_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_file_sel == 2'd1) |->
      (rdata[BUS_W-1:ADDR_W] == {(BUS_W-ADDR_W){rdata[ADDR_W-1]}}));

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> rdata == '0);

  assert_none_file_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_file_sel == 2'd3) |-> rdata == '0);

  assert_index_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!access_valid && !reg_wr) |=> $stable(idx_flat));
endmodule

bind circ_addr_gen dag_addr_checker #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .NREG(NREG)
) u_dag_addr_checker (
  .clk(clk), .rst_n(rst_n), .access_valid(access_valid), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_file_sel(reg_file_sel), .rdata(rdata), .idx_flat(idx_flat)
);

// File: tb/test_circ_addr_gen.sv
module test_circ_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        access_valid, bitrev_en, reg_wr, reg_rd;
  logic [1:0]  i_sel, m_sel, reg_file_sel, reg_idx;
  logic [13:0] addr_out;
  logic [15:0] wdata, rdata;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  circ_addr_gen i_circ_addr_gen (
    .clk(clk), .rst_n(rst_n), .access_valid(access_valid), .i_sel(i_sel),
    .m_sel(m_sel), .bitrev_en(bitrev_en), .addr_out(addr_out), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_file_sel(reg_file_sel), .reg_idx(reg_idx),
    .wdata(wdata), .rdata(rdata)
  );

  typedef struct packed {
    logic [1:0]  op;     // 0 write, 1 read+check, 2 access+check addr
    logic [1:0]  fsel;
    logic [1:0]  idx;
    logic [1:0]  msel;
    logic        brev;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0010, 16'h0000, 4'd3},  // I0=0x10
    '{2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 16'h0003, 16'h0000, 4'd3},  // M0=3
    '{2'd2, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0010, 4'd2},  // R2 pre-modify addr
    '{2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0013, 4'd3},  // R3
    '{2'd2, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0013, 4'd2},
    '{2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0016, 4'd3},
    '{2'd0, 2'd1, 2'd1, 2'd0, 1'b0, 16'hFFFE, 16'h0000, 4'd4},  // M1=-2
    '{2'd1, 2'd1, 2'd1, 2'd0, 1'b0, 16'h0000, 16'hFFFE, 4'd9},  // R9 sign fill
    '{2'd2, 2'd0, 2'd0, 2'd1, 1'b0, 16'h0000, 16'h0016, 4'd4},
    '{2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0014, 4'd4},  // R4 down-step
    '{2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 16'h0001, 16'h0000, 4'd5},  // I1=1
    '{2'd2, 2'd0, 2'd1, 2'd1, 1'b0, 16'h0000, 16'h0001, 4'd5},
    '{2'd1, 2'd0, 2'd1, 2'd0, 1'b0, 16'h0000, 16'h3FFF, 4'd5},  // R5 linear underflow
    '{2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0014, 4'd3},  // R3 I0 untouched
    '{2'd0, 2'd2, 2'd2, 2'd0, 1'b0, 16'h0005, 16'h0000, 4'd6},  // L2=5
    '{2'd0, 2'd0, 2'd2, 2'd0, 1'b0, 16'h0023, 16'h0000, 4'd6},  // I2=0x23
    '{2'd0, 2'd1, 2'd2, 2'd0, 1'b0, 16'h0002, 16'h0000, 4'd6},  // M2=2
    '{2'd2, 2'd0, 2'd2, 2'd2, 1'b0, 16'h0000, 16'h0023, 4'd6},
    '{2'd1, 2'd0, 2'd2, 2'd0, 1'b0, 16'h0000, 16'h0020, 4'd6},  // R6 upper wrap
    '{2'd2, 2'd0, 2'd2, 2'd2, 1'b0, 16'h0000, 16'h0020, 4'd6},
    '{2'd1, 2'd0, 2'd2, 2'd0, 1'b0, 16'h0000, 16'h0022, 4'd6},  // R6 inside buffer
    '{2'd2, 2'd0, 2'd2, 2'd1, 1'b0, 16'h0000, 16'h0022, 4'd7},
    '{2'd1, 2'd0, 2'd2, 2'd0, 1'b0, 16'h0000, 16'h0020, 4'd7},
    '{2'd2, 2'd0, 2'd2, 2'd1, 1'b0, 16'h0000, 16'h0020, 4'd7},
    '{2'd1, 2'd0, 2'd2, 2'd0, 1'b0, 16'h0000, 16'h0023, 4'd7},  // R7 lower wrap
    '{2'd0, 2'd0, 2'd3, 2'd0, 1'b0, 16'h0001, 16'h0000, 4'd8},  // I3=1
    '{2'd2, 2'd0, 2'd3, 2'd0, 1'b1, 16'h0000, 16'h2000, 4'd8},  // R8 reversed addr
    '{2'd1, 2'd0, 2'd3, 2'd0, 1'b0, 16'h0000, 16'h0004, 4'd8},  // R8 normal-order update
    '{2'd2, 2'd0, 2'd3, 2'd0, 1'b1, 16'h0000, 16'h0800, 4'd8},
    '{2'd2, 2'd0, 2'd3, 2'd0, 1'b0, 16'h0000, 16'h0007, 4'd2},
    '{2'd0, 2'd2, 2'd3, 2'd0, 1'b0, 16'hC005, 16'h0000, 4'd9},
    '{2'd1, 2'd2, 2'd3, 2'd0, 1'b0, 16'h0000, 16'h0005, 4'd9},  // R9 upper write bits dropped
    '{2'd0, 2'd0, 2'd3, 2'd0, 1'b0, 16'hFFFF, 16'h0000, 4'd9},
    '{2'd1, 2'd0, 2'd3, 2'd0, 1'b0, 16'h0000, 16'h3FFF, 4'd9},  // R9 zero pad on index
    '{2'd1, 2'd1, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0003, 4'd9},
    '{2'd0, 2'd3, 2'd0, 2'd0, 1'b0, 16'h1234, 16'h0000, 4'd11},
    '{2'd1, 2'd3, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0000, 4'd11}, // R11 empty bank
    '{2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0014, 4'd11},
    '{2'd1, 2'd1, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0003, 4'd11}
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    access_valid = 1'b0; bitrev_en = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    i_sel = '0; m_sel = '0; reg_file_sel = '0; reg_idx = '0; wdata = '0;
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    idle_inputs();
    case (v.op)
      2'd0: begin reg_wr = 1'b1; reg_file_sel = v.fsel; reg_idx = v.idx; wdata = v.data; end
      2'd1: begin reg_rd = 1'b1; reg_file_sel = v.fsel; reg_idx = v.idx; end
      default: begin access_valid = 1'b1; i_sel = v.idx; m_sel = v.msel; bitrev_en = v.brev; end
    endcase
    #2;
    if (v.op == 2'd1) check(int'(v.req), rdata, v.exp);
    if (v.op == 2'd2) check(int'(v.req), {2'b00, addr_out}, v.exp);
  endtask

  task automatic read_reg(input int req, input logic [1:0] f, input logic [1:0] k,
                          input logic [15:0] exp);
    @(negedge clk);
    idle_inputs();
    reg_rd = 1'b1; reg_file_sel = f; reg_idx = k;
    #2;
    check(req, rdata, exp);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: all banks clear after reset
    for (int f = 0; f < 3; f++)
      for (int k = 0; k < 4; k++)
        read_reg(1, 2'(f), 2'(k), 16'h0000);

    for (int n = 0; n < NV; n++) run_vec(VECS[n]);

    // R10: write and post-modify of I0 in one cycle, write kept
    @(negedge clk);
    idle_inputs();
    access_valid = 1'b1; i_sel = 2'd0; m_sel = 2'd0;
    reg_wr = 1'b1; reg_file_sel = 2'd0; reg_idx = 2'd0; wdata = 16'h0100;
    read_reg(10, 2'd0, 2'd0, 16'h0100);

    // R12: selects set but no access and no write, index unchanged
    @(negedge clk);
    idle_inputs();
    i_sel = 2'd0; m_sel = 2'd0;
    read_reg(12, 2'd0, 2'd0, 16'h0100);

    // R11: bus reads zero when reg_rd is low
    @(negedge clk);
    idle_inputs();
    reg_file_sel = 2'd0; reg_idx = 2'd0;
    #2;
    check(11, rdata, 16'h0000);

    // R1: a second reset clears written registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_reg(1, 2'd0, 2'd0, 16'h0000);
    read_reg(1, 2'd2, 2'd3, 16'h0000);
    read_reg(1, 2'd1, 2'd1, 16'h0000);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule